// File: doc/BRIEF.md
# Two-Dimensional Parity Corrector for Flit Groups

This block protects a link that carries groups of flits. On the sending side it appends one even-parity bit to every data word. After a fixed number of data flits it also appends a check flit, which is the bitwise XOR of the flits already sent. On the receiving side it stores a whole group and records, for each flit, whether that flit's parity fails. It also XORs every flit of the group, the check flit included, into a column syndrome.

When the check flit arrives, the receiver looks at the two syndromes together:
- **No bit set in either:** the group is released unchanged.
- **Exactly one failing flit and exactly one failing bit position:** the bit where they cross is inverted as the flits are read out.
- **Any other pattern:** the group is dropped. The receiver pulses a retransmission request that carries the column syndrome, so the sender can resend the marked bit positions.

The data width and the group length are parameters. The buffer holds exactly one group.

Top module: `ppc_rx_corrector`

## Requirements
- R1: While the sender is taking data, its output flit carries the data word in bits N-1..0 and, in bit N, the XOR of those data bits.
- R2: After M data flits, the sender offers a check flit equal to the bitwise XOR of the M flits it produced. While the check flit is offered, `enc_in_ready` is low, and the flit is held until `enc_out_ready` takes it.
- R3: Out of reset, `rx_ready` is 1, `out_valid` is 0 and `retx_valid` is 0. The receiver accepts M data flits followed by one check flit. It then holds `rx_ready` low until the group is resolved.
- R4: A group with no flipped bit is delivered as M outputs in arrival order, with the data unchanged.
- R5: One flipped data bit anywhere in the group, including the first and last flit and the edge bit positions, is inverted back at readout.
- R6: A single flip of a data flit's parity bit (bit N) is recognised as correctable. The data of that flit is delivered unchanged.
- R7: Two flipped bits inside one flit produce a one-cycle `retx_valid` pulse. `retx_index` holds 1s at exactly those bit positions, and no flit of the group is delivered.
- R8: Any other non-correctable pattern also produces the request instead of output. Examples are single faults in two different flits, or a single fault inside the check flit.
- R9: `out_last` is high only together with the M-th output flit. While `out_ready` is low, `out_valid`, `out_data` and `out_last` hold.
- R10: `retx_valid` lasts exactly one cycle, and `rx_ready` is high in that same cycle.
- R11: Four flips on the corners of a rectangle (two flits × two bit positions) leave both syndromes zero. The group is then delivered as received, with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_in_valid | input | 1 | Sender: data word offered |
| enc_in_data | input | N | Sender: data word |
| enc_in_ready | output | 1 | Sender: data word taken |
| enc_out_valid | output | 1 | Sender: coded flit offered |
| enc_out_flit | output | N+1 | Sender: coded flit, parity in bit N |
| enc_out_ready | input | 1 | Sender: link takes the flit |
| rx_valid | input | 1 | Receiver: flit offered |
| rx_flit | input | N+1 | Receiver: received flit, parity in bit N |
| rx_ready | output | 1 | Receiver: flit taken |
| out_valid | output | 1 | Corrected data valid |
| out_data | output | N | Corrected data word |
| out_last | output | 1 | Marks the M-th flit of the group |
| out_ready | input | 1 | Consumer takes the data word |
| retx_valid | output | 1 | One-cycle retransmission request |
| retx_index | output | N+1 | Failing bit positions (column syndrome) |

## Verification
The hardest cases to reach are the fault patterns whose syndromes look benign or misleading:
- a double flip inside one flit, which leaves every row check clean;
- the four-corner rectangle, which cancels both syndromes;
- a flip in the check flit itself.

The bench reaches these by building a correct group in software and then XORing a chosen fault mask into the individual flits before sending them. Each scenario places the flips at known crossings, so the exact request vector or the exact delivered words can be predicted.

// File: rtl/ppc_rx_corrector.sv
module ppc_rx_corrector #(
  parameter int N = 8,
  parameter int M = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enc_in_valid,
  input  logic [N-1:0] enc_in_data,
  output logic         enc_in_ready,
  output logic         enc_out_valid,
  output logic [N:0]   enc_out_flit,
  input  logic         enc_out_ready,
  input  logic         rx_valid,
  input  logic [N:0]   rx_flit,
  output logic         rx_ready,
  output logic         out_valid,
  output logic [N-1:0] out_data,
  output logic         out_last,
  input  logic         out_ready,
  output logic         retx_valid,
  output logic [N:0]   retx_index
);
  localparam int EW = (M > 1) ? $clog2(M) : 1;
  localparam int CW = $clog2(M + 1);

  // ---------------- sender ----------------
  logic [EW-1:0] ecnt;
  logic          pf_pend;
  logic [N:0]    eacc;
  logic [N:0]    data_flit;

  assign data_flit     = {^enc_in_data, enc_in_data};
  assign enc_out_valid = pf_pend | enc_in_valid;
  assign enc_out_flit  = pf_pend ? eacc : data_flit;
  assign enc_in_ready  = ~pf_pend & enc_out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ecnt    <= '0;
      pf_pend <= 1'b0;
      eacc    <= '0;
    end else if (pf_pend) begin
      if (enc_out_ready) begin
        pf_pend <= 1'b0;
        ecnt    <= '0;
      end
    end else if (enc_in_valid && enc_out_ready) begin
      eacc <= (ecnt == '0) ? data_flit : (eacc ^ data_flit);
      if (ecnt == EW'(M - 1)) pf_pend <= 1'b1;
      else                    ecnt    <= ecnt + 1'b1;
    end
  end

  // R2
  pf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_pend && !enc_out_ready |=> pf_pend && $stable(enc_out_flit) && !enc_in_ready);

  // ---------------- receiver ----------------
  typedef enum logic [1:0] {S_RECV, S_EVAL, S_SEND} st_t;
  st_t           st;
  logic [CW-1:0] cnt;
  logic [EW-1:0] rd;
  logic [N-1:0]  dbuf [M];
  logic [M-1:0]  cf_vec;
  logic [N:0]    cp;
  logic          cf_one, cp_one, fixable;

  assign rx_ready  = (st == S_RECV);
  assign out_valid = (st == S_SEND);
  assign out_last  = out_valid && (rd == EW'(M - 1));
  assign out_data  = dbuf[rd] ^ (cf_vec[rd] ? cp[N-1:0] : '0);

  assign cf_one  = (cf_vec != '0) && ((cf_vec & (cf_vec - 1'b1)) == '0);
  assign cp_one  = (cp != '0) && ((cp & (cp - 1'b1)) == '0);
  assign fixable = ((cf_vec == '0) && (cp == '0)) || (cf_one && cp_one);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_RECV;
      cnt        <= '0;
      rd         <= '0;
      cf_vec     <= '0;
      cp         <= '0;
      retx_valid <= 1'b0;
      retx_index <= '0;
    end else begin
      retx_valid <= 1'b0;
      case (st)
        S_RECV: if (rx_valid) begin
          cp <= (cnt == '0) ? rx_flit : (cp ^ rx_flit);
          if (cnt == CW'(M)) begin
            cnt <= '0;
            st  <= S_EVAL;
          end else begin
            cf_vec[cnt[EW-1:0]] <= ^rx_flit;
            cnt <= cnt + 1'b1;
          end
        end
        S_EVAL: begin
          if (fixable) begin
            st <= S_SEND;
            rd <= '0;
          end else begin
            retx_valid <= 1'b1;
            retx_index <= cp;
            st         <= S_RECV;
          end
        end
        default: if (out_ready) begin
          if (rd == EW'(M - 1)) begin
            rd <= '0;
            st <= S_RECV;
          end else begin
            rd <= rd + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_RECV && rx_valid && cnt != CW'(M))
      dbuf[cnt[EW-1:0]] <= rx_flit[N-1:0];
  end

  // R3
  rx_out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !out_valid);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R9
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R10
  retx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retx_valid |=> !retx_valid);

  // R10
  retx_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retx_valid |-> rx_ready && !out_valid);
endmodule

// File: tb/ppc_rx_corrector_tb_top.sv
`timescale 1ns/1ps
module ppc_rx_corrector_tb_top;
  localparam int N = 8;
  localparam int M = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enc_in_valid = 1'b0, enc_out_ready = 1'b1;
  logic [N-1:0] enc_in_data = '0;
  logic enc_in_ready, enc_out_valid;
  logic [N:0] enc_out_flit;
  logic rx_valid = 1'b0;
  logic [N:0] rx_flit = '0;
  logic rx_ready, out_valid, out_last, retx_valid;
  logic [N-1:0] out_data;
  logic out_ready = 1'b1;
  logic [N:0] retx_index;

  int n_chk = 0, n_fail = 0, cyc = 0;

  logic [N-1:0] gdata [M];
  logic [N:0]   gfault [M+1];
  logic [N-1:0] obuf [M];
  logic         olast [M];
  int           ocount;
  logic         retx_seen;
  logic [N:0]   retx_vec;

  always #4 clk = ~clk;

  ppc_rx_corrector #(.N(N), .M(M)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .enc_in_valid(enc_in_valid), .enc_in_data(enc_in_data), .enc_in_ready(enc_in_ready),
    .enc_out_valid(enc_out_valid), .enc_out_flit(enc_out_flit), .enc_out_ready(enc_out_ready),
    .rx_valid(rx_valid), .rx_flit(rx_flit), .rx_ready(rx_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
    .retx_valid(retx_valid), .retx_index(retx_index));

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_faults();
    for (int i = 0; i <= M; i++) gfault[i] = '0;
  endtask

  task automatic run_group(input bit stall);
    logic [N:0] f [M+1];
    logic [N:0] acc;
    bit stalled;
    acc = '0;
    for (int i = 0; i < M; i++) begin
      f[i] = {^gdata[i], gdata[i]};
      acc  = acc ^ f[i];
    end
    f[M] = acc;
    for (int i = 0; i <= M; i++) f[i] = f[i] ^ gfault[i];
    for (int i = 0; i <= M; i++) begin
      @(negedge clk);
      while (!rx_ready) @(negedge clk);
      rx_valid = 1'b1;
      rx_flit  = f[i];
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    // R3: busy while the group is being resolved
    chk(rx_ready == 1'b0, "R3 rx_ready low after group", 32'(rx_ready), 32'd0);
    ocount = 0; retx_seen = 0; retx_vec = '0; stalled = 0;
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      if (retx_valid) begin
        retx_seen = 1; retx_vec = retx_index;
        // R10
        chk(rx_ready == 1'b1, "R10 rx_ready during request", 32'(rx_ready), 32'd1);
        @(negedge clk);
        chk(retx_valid == 1'b0, "R10 request lasts one cycle", 32'(retx_valid), 32'd0);
        break;
      end
      if (stall && ocount == 1 && !stalled && out_valid) begin
        logic [N-1:0] held;
        held = out_data;
        out_ready = 1'b0;
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk(out_valid && out_data == held && !out_last, "R9 output held while stalled", 32'(out_data), 32'(held));
        end
        out_ready = 1'b1;
        stalled = 1;
      end
      if (out_valid) begin
        obuf[ocount]  = out_data;
        olast[ocount] = out_last;
        ocount++;
        if (out_last || ocount == M) begin
          @(negedge clk);
          break;
        end
      end
    end
  endtask

  task automatic expect_out(input string req, input logic [N-1:0] e [M]);
    chk(retx_seen == 0, {req, " no request"}, 32'(retx_seen), 32'd0);
    chk(ocount == M, {req, " output count"}, 32'(ocount), 32'(M));
    for (int i = 0; i < M; i++) begin
      chk(obuf[i] == e[i], {req, " data"}, 32'(obuf[i]), 32'(e[i]));
      // R9: last marker only on the final flit
      chk(olast[i] == (i == M - 1), "R9 out_last position", 32'(olast[i]), 32'(i == M - 1));
    end
  endtask

  task automatic load_default();
    gdata[0] = 8'h12; gdata[1] = 8'h34; gdata[2] = 8'hA5; gdata[3] = 8'h0F;
    clear_faults();
  endtask

  task automatic t_reset();
    chk(rx_ready == 1 && out_valid == 0 && retx_valid == 0, "R3 reset state",
        {29'd0, rx_ready, out_valid, retx_valid}, 32'h4);
  endtask

  task automatic t_encode();
    logic [N-1:0] d [M];
    logic [N:0] acc;
    d[0] = 8'h81; d[1] = 8'h7E; d[2] = 8'h03; d[3] = 8'hF0;
    acc = '0;
    for (int i = 0; i < M; i++) begin
      @(negedge clk);
      enc_in_valid = 1; enc_in_data = d[i];
      #1;
      chk(enc_in_ready && enc_out_flit == {^d[i], d[i]}, "R1 coded data flit",
          32'(enc_out_flit), 32'({^d[i], d[i]}));
      acc = acc ^ {^d[i], d[i]};
      @(posedge clk);
    end
    @(negedge clk);
    enc_in_data = 8'h55; enc_out_ready = 0;
    chk(!enc_in_ready && enc_out_valid && enc_out_flit == acc, "R2 check flit offered",
        32'(enc_out_flit), 32'(acc));
    @(negedge clk);
    chk(!enc_in_ready && enc_out_flit == acc, "R2 check flit held", 32'(enc_out_flit), 32'(acc));
    enc_out_ready = 1;
    @(negedge clk);
    chk(enc_in_ready && enc_out_flit == {^enc_in_data, enc_in_data}, "R2 next group resumes",
        32'(enc_out_flit), 32'({^enc_in_data, enc_in_data}));
    enc_in_valid = 0;
  endtask

  task automatic t_clean();
    load_default();
    run_group(0);
    expect_out("R4 clean group", gdata);
  endtask

  task automatic t_single_mid();
    load_default();
    gfault[2][5] = 1'b1;
    run_group(1);
    expect_out("R5 single flip flit2 bit5", gdata);
  endtask

  task automatic t_single_edges();
    load_default();
    gdata[0] = 8'hC3;
    gfault[0][0] = 1'b1;
    run_group(0);
    expect_out("R5 single flip first flit bit0", gdata);
    load_default();
    gfault[M-1][N-1] = 1'b1;
    run_group(0);
    expect_out("R5 single flip last flit top bit", gdata);
  endtask

  task automatic t_parity_bit();
    load_default();
    gfault[1][N] = 1'b1;
    run_group(0);
    expect_out("R6 parity bit flip", gdata);
  endtask

  task automatic t_double_in_flit();
    load_default();
    gfault[3][2] = 1'b1; gfault[3][6] = 1'b1;
    run_group(0);
    chk(retx_seen == 1 && retx_vec == 9'h044, "R7 row request vector", 32'(retx_vec), 32'h044);
    chk(ocount == 0, "R7 no output", 32'(ocount), 32'd0);
  endtask

  task automatic t_two_flits();
    load_default();
    gfault[0][1] = 1'b1; gfault[2][7] = 1'b1;
    run_group(0);
    chk(retx_seen == 1 && retx_vec == 9'h082, "R8 two faulty flits", 32'(retx_vec), 32'h082);
    chk(ocount == 0, "R8 no output", 32'(ocount), 32'd0);
    load_default();
    gfault[M][3] = 1'b1;
    run_group(0);
    chk(retx_seen == 1 && retx_vec == 9'h008, "R8 fault in check flit", 32'(retx_vec), 32'h008);
  endtask

  task automatic t_rectangle();
    logic [N-1:0] e [M];
    load_default();
    gfault[0][1] = 1; gfault[0][4] = 1; gfault[2][1] = 1; gfault[2][4] = 1;
    for (int i = 0; i < M; i++) e[i] = gdata[i] ^ gfault[i][N-1:0];
    run_group(0);
    expect_out("R11 rectangle undetected", e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_encode();
    t_clean();
    t_single_mid();
    t_single_edges();
    t_parity_bit();
    t_double_in_flit();
    t_two_flits();
    t_rectangle();
    t_clean();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule